// File: doc/BRIEF.md
# TDMA Node Startup Controller

This block brings a node on a shared, arbitrated bus from power-on into a running time-division schedule. After reset it stays silent and listens. If any frame is received while listening, the schedule position carried in that frame's identifier (current slot and current round) is handed to the node's slot and round counters through a one-cycle load command. The node is then synchronized.

If the listen window ends with no traffic, the node enters coldstart and raises a transmit request for its own first frame, which has slot 0 and round 0. Two nodes that start coldstart together are sorted out by the bus's non-destructive bitwise arbitration. The winner's frame completes and the winner starts the schedule at 0:0. A loser withdraws its request, waits for the winning frame, and takes its time base from that frame's identifier. The frame engine has no automatic retransmission and no error signalling, so a lost or failed frame never spills into the following slot. Once synchronized, the node stays synchronized until the next reset.

Top module: `tdma_startup_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, load_en, tx_req and synced are 0, and load_slot and load_round are 0.
- R2: While the node is listening, tx_req stays 0.
- R3: An rx_valid pulse during listening gives, after the next clock edge, a single-cycle load_en with load_slot = rx_id[SLOT_W-1:0] and load_round = rx_id[SLOT_W+ROUND_W-1:SLOT_W], and synced rises in that same cycle.
- R4: If rx_valid stays low for LISTEN_CYC clock cycles after reset is released, tx_req rises after the LISTEN_CYC-th edge. tx_id is always {NODE_PRIO, round 0, slot 0}, with the priority in the bits above the round field.
- R5: Once raised, tx_req stays high until tx_done, arb_lost or rx_valid is seen.
- R6: tx_done in coldstart with no arbitration loss gives, one edge later, a load_en pulse with slot 0 and round 0, drops tx_req and raises synced.
- R7: arb_lost in coldstart drops tx_req after the next edge and does not set synced. The next rx_valid then loads that frame's slot and round and sets synced.
- R8: While the node waits for the winning frame after losing arbitration, tx_done has no effect: there is no load_en, and tx_req and synced stay 0.
- R9: Once synced is 1, it stays 1 until reset, and rx_valid, tx_done and arb_lost produce no further load_en and no tx_req.
- R10: rx_valid takes priority both over the listen timeout ending in the same cycle and over tx_done in the same cycle during coldstart. In either case the received frame's slot and round are loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Single-cycle pulse: a frame was received |
| rx_id | input | ID_W | Identifier of the received frame |
| tx_done | input | 1 | The own frame completed on the bus |
| arb_lost | input | 1 | The own frame lost arbitration |
| load_en | output | 1 | Single-cycle command to load the slot and round counters |
| load_slot | output | SLOT_W | Slot value to load |
| load_round | output | ROUND_W | Round value to load |
| tx_req | output | 1 | Request to send the coldstart frame |
| tx_id | output | ID_W | Identifier of the coldstart frame |
| synced | output | 1 | The node follows the schedule |

## Verification
The assertions check the following on every cycle:
- load_en is never two cycles long;
- synced never falls;
- synced rises only together with a load;
- the request never coexists with synced;
- the request persists with no terminating event and drops after a loss;
- the listen counter never passes its limit.

Only the bench scenarios can show the rest:
- the exact cycle at which the listen timeout ends;
- the slot and round values taken from an identifier;
- that tx_done is ignored after a lost arbitration;
- which event wins when a reception coincides with the timeout or with tx_done.

// File: rtl/tdma_start_pkg.sv
package tdma_start_pkg;
  typedef enum logic [1:0] {
    ST_LISTEN = 2'd0,
    ST_COLD   = 2'd1,
    ST_LOST   = 2'd2,
    ST_SYNC   = 2'd3
  } start_state_e;
endpackage

// File: rtl/tdma_listen_timer.sv
module tdma_listen_timer #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/tdma_id_fields.sv
module tdma_id_fields #(
  parameter int SLOT_W  = 4,
  parameter int ROUND_W = 2,
  parameter int PRIO_W  = 5,
  localparam int ID_W   = SLOT_W + ROUND_W + PRIO_W
) (
  input  logic [ID_W-1:0]    id,
  output logic [SLOT_W-1:0]  slot,
  output logic [ROUND_W-1:0] round
);
  logic prio_unused;
  assign slot        = id[SLOT_W-1:0];
  assign round       = id[SLOT_W+ROUND_W-1:SLOT_W];
  assign prio_unused = ^id[ID_W-1:SLOT_W+ROUND_W];
endmodule

// File: rtl/tdma_startup_ctrl.sv
module tdma_startup_ctrl
  import tdma_start_pkg::*;
#(
  parameter int SLOT_W     = 4,
  parameter int ROUND_W    = 2,
  parameter int PRIO_W     = 5,
  parameter int LISTEN_CYC = 1000,
  parameter int NODE_PRIO  = 1,
  localparam int ID_W      = SLOT_W + ROUND_W + PRIO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic [ID_W-1:0]    rx_id,
  input  logic               tx_done,
  input  logic               arb_lost,
  output logic               load_en,
  output logic [SLOT_W-1:0]  load_slot,
  output logic [ROUND_W-1:0] load_round,
  output logic               tx_req,
  output logic [ID_W-1:0]    tx_id,
  output logic               synced
);
  start_state_e state, nxt_state;
  logic               listen_over;
  logic [SLOT_W-1:0]  rx_slot;
  logic [ROUND_W-1:0] rx_round;
  logic               nxt_load, nxt_req;
  logic [SLOT_W-1:0]  nxt_slot;
  logic [ROUND_W-1:0] nxt_round;

  tdma_listen_timer #(.LIMIT(LISTEN_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_LISTEN), .expire(listen_over)
  );

  tdma_id_fields #(.SLOT_W(SLOT_W), .ROUND_W(ROUND_W), .PRIO_W(PRIO_W)) u_fields (
    .id(rx_id), .slot(rx_slot), .round(rx_round)
  );

  assign tx_id = {PRIO_W'(NODE_PRIO), ROUND_W'(0), SLOT_W'(0)};

  always_comb begin
    nxt_state = state;
    nxt_load  = 1'b0;
    nxt_req   = tx_req;
    nxt_slot  = load_slot;
    nxt_round = load_round;
    unique case (state)
      ST_LISTEN: begin
        if (rx_valid) begin
          nxt_load = 1'b1; nxt_slot = rx_slot; nxt_round = rx_round;
          nxt_state = ST_SYNC;
        end else if (listen_over) begin
          nxt_req = 1'b1; nxt_state = ST_COLD;
        end
      end
      ST_COLD: begin
        if (rx_valid) begin
          nxt_load = 1'b1; nxt_slot = rx_slot; nxt_round = rx_round;
          nxt_req = 1'b0; nxt_state = ST_SYNC;
        end else if (arb_lost) begin
          nxt_req = 1'b0; nxt_state = ST_LOST;
        end else if (tx_done) begin
          nxt_load = 1'b1; nxt_slot = '0; nxt_round = '0;
          nxt_req = 1'b0; nxt_state = ST_SYNC;
        end
      end
      ST_LOST: begin
        if (rx_valid) begin
          nxt_load = 1'b1; nxt_slot = rx_slot; nxt_round = rx_round;
          nxt_state = ST_SYNC;
        end
      end
      default: nxt_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_LISTEN;
      load_en    <= 1'b0;
      load_slot  <= '0;
      load_round <= '0;
      tx_req     <= 1'b0;
      synced     <= 1'b0;
    end else begin
      state      <= nxt_state;
      load_en    <= nxt_load;
      load_slot  <= nxt_slot;
      load_round <= nxt_round;
      tx_req     <= nxt_req;
      synced     <= (nxt_state == ST_SYNC);
    end
  end

  // R3
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !load_en);
  // R9
  sync_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    synced |=> synced);
  // R6
  sync_with_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(synced) |-> load_en);
  // R2
  req_unsynced_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> !synced);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_done && !arb_lost && !rx_valid) |=> tx_req);
  // R7
  lost_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && arb_lost) |=> !tx_req);
endmodule

// File: tb/tdma_startup_ctrl_test.sv
module tdma_startup_ctrl_test;
  localparam int SW = 3, RW = 2, PW = 3, LC = 8, NP = 5;
  localparam int IW = SW + RW + PW;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 1'b0, tx_done = 1'b0, arb_lost = 1'b0;
  logic [IW-1:0] rx_id = '0;
  logic load_en, tx_req, synced;
  logic [SW-1:0] load_slot;
  logic [RW-1:0] load_round;
  logic [IW-1:0] tx_id;

  int vectors = 0, errors = 0;
  bit finished = 0;

  int m_state = 0, m_tmr = 0, m_load = 0, m_slot = 0, m_round = 0, m_req = 0, m_sync = 0;

  always #10 clk = ~clk;

  tdma_startup_ctrl #(.SLOT_W(SW), .ROUND_W(RW), .PRIO_W(PW), .LISTEN_CYC(LC),
                      .NODE_PRIO(NP)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .tx_done(tx_done),
    .arb_lost(arb_lost), .load_en(load_en), .load_slot(load_slot),
    .load_round(load_round), .tx_req(tx_req), .tx_id(tx_id), .synced(synced)
  );

  task automatic adopt(input int id);
    m_load = 1; m_slot = id % (1 << SW); m_round = (id >> SW) % (1 << RW);
    m_state = 3; m_sync = 1; m_req = 0;
  endtask

  task automatic model(input bit r, input bit rx, input int id, input bit dn, input bit ls);
    m_load = 0;
    if (r) begin
      m_state = 0; m_tmr = 0; m_slot = 0; m_round = 0; m_req = 0; m_sync = 0;
    end else begin
      case (m_state)
        0: if (rx) adopt(id);
           else if (m_tmr == LC - 1) begin m_state = 1; m_req = 1; end
           else m_tmr++;
        1: if (rx) adopt(id);
           else if (ls) begin m_req = 0; m_state = 2; end
           else if (dn) begin m_load = 1; m_slot = 0; m_round = 0; m_req = 0;
                              m_state = 3; m_sync = 1; end
        2: if (rx) adopt(id);
        default: ;
      endcase
      if (m_state != 0) m_tmr = 0;
    end
  endtask

  task automatic step(input bit r, input bit rx, input int id, input bit dn,
                      input bit ls, input string tag);
    @(negedge clk);
    rst = r; rx_valid = rx; rx_id = IW'(id); tx_done = dn; arb_lost = ls;
    @(posedge clk);
    model(r, rx, id, dn, ls);
    #5;
    vectors++;
    if (load_en !== m_load[0] || load_slot !== SW'(m_slot) || load_round !== RW'(m_round)
        || tx_req !== m_req[0] || synced !== m_sync[0]) begin
      errors++;
      $display("FAIL %s: got load=%0b slot=%0d round=%0d req=%0b sync=%0b exp load=%0d slot=%0d round=%0d req=%0d sync=%0d",
               tag, load_en, load_slot, load_round, tx_req, synced,
               m_load, m_slot, m_round, m_req, m_sync);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    // Scenario A: a frame heard during listening, then sticky sync
    do_reset();
    idle(3, "R2");
    step(0, 1, (2 << 5) | (3 << 3) | 6, 0, 0, "R3");
    idle(2, "R3");
    step(0, 1, 9, 0, 0, "R9");
    step(0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 1, "R9");
    idle(LC + 2, "R9");
    // Scenario B: silent bus, coldstart wins
    do_reset();
    idle(LC - 1, "R2");
    idle(1, "R4");
    idle(4, "R5");
    step(0, 0, 0, 1, 0, "R6");
    idle(3, "R6");
    // Scenario C: coldstart loses arbitration
    do_reset();
    idle(LC, "R4");
    idle(2, "R5");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 0, "R8");
    idle(3, "R8");
    step(0, 1, (1 << 5) | (2 << 3) | 5, 0, 0, "R7");
    idle(2, "R7");
    // Scenario D: a frame arriving in the last listening cycle
    do_reset();
    idle(LC - 1, "R2");
    step(0, 1, (1 << 3) | 4, 0, 0, "R10");
    idle(LC + 1, "R10");
    // Scenario E: a frame and tx_done in the same coldstart cycle
    do_reset();
    idle(LC + 1, "R5");
    step(0, 1, (3 << 3) | 7, 1, 0, "R10");
    idle(2, "R10");
    // coldstart identifier
    vectors++;
    if (tx_id !== IW'((NP << (SW + RW)))) begin
      errors++;
      $display("FAIL R4: tx_id got %0h exp %0h", tx_id, NP << (SW + RW));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule